// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block moves one byte out and one byte in at the same time over a three-wire serial link: a serial clock, a data output and a data input. As master it makes the serial clock from the system clock through a programmable divider. As slave it follows a serial clock driven by the far end. One configuration bit selects between a normal edge scheme and an SPI-compatible edge scheme. A second bit inverts the clock polarity. A third bit picks MSB-first or LSB-first bit order.

Software uses a small register port with four addresses. It loads a transmit holding register and reads back a receive holding register. Status flags and three interrupt requests report progress. A receive overrun keeps the byte already held, and writing 1 to a dedicated clear bit clears the overrun flag. A transfer starts when transmit is enabled, a byte is pending and the shifter is idle. The frame is always 8 bits.

Register map, selected by `reg_addr`:
- 0: configuration. Bit 0 is the transmit enable, 1 the receive enable, 2 slave select (0 is master, 1 is slave), 3 SPI timing, 4 clock invert, 5 LSB-first, 6 clock output enable, 7 data output enable.
- 1: interrupt enables. Bit 0 is for receive, 1 for transmit, 2 for bus idle. Bit 7 is the write-1 overrun clear and always reads 0.
- 2: a write loads the transmit holding register. A read returns the receive holding register and clears receive-full.
- 3: a write sets the divider. A read returns status: bit 0 receive-full, bit 1 transmit-empty, bit 2 bus-idle, bit 3 overrun.

Top module: `sync_serial_xcvr`

## Requirements
- R1: After reset the status reads transmit-empty 1, bus-idle 1, receive-full 0 and overrun 0 (status value 0x06), and all configuration and enable bits read 0.
- R2: In master mode the serial clock holds its idle level (high when clock invert is 0, low when it is 1) outside a transfer. Each half-period lasts divider+1 system clocks, and a frame has 16 clock edges.
- R3: In normal timing with clock invert 0, data out changes on falling edges and data in is sampled on rising edges. With clock invert 1 these edges swap.
- R4: In SPI timing with clock invert 0, data out changes on rising edges and data in is sampled on falling edges. The first bit is on the line before the first edge. With clock invert 1 these edges swap.
- R5: With LSB-first at 0, bit 7 goes first in both directions. With LSB-first at 1, bit 0 goes first.
- R6: Writing the data register clears transmit-empty. Transmit-empty returns to 1 when the byte moves into the shifter. Bus-idle is 1 only when the shifter is idle and transmit-empty is 1.
- R7: When a frame completes with receive enabled and receive-full at 0, the byte goes into the receive holding register and receive-full is set. Reading the data register clears receive-full.
- R8: When a frame completes while receive-full is 1, overrun is set and the held byte is kept. Writing 1 to bit 7 of address 1 clears overrun.
- R9: Each interrupt request is high exactly while its flag and its enable bit are both 1. Receive uses receive-full, transmit uses transmit-empty, and bus idle uses bus-idle.
- R10: With the clock output enable at 0 the serial clock output stays at its idle level. With the data output enable at 0 the data output stays at 1.
- R11: With transmit enable at 0 no transfer starts and a written byte stays pending. With receive enable at 0 a completed frame leaves receive-full at 0.
- R12: In slave mode the serial clock comes from `sck_in` through a synchronizer, and the same edge scheme, bit order and flags apply as in master mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears receive-full on a data read) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| sck_in | input | 1 | External serial clock used in slave mode |
| sdi | input | 1 | Serial data input |
| sck_out | output | 1 | Serial clock output in master mode |
| sdo_out | output | 1 | Serial data output |
| irq_rx | output | 1 | Receive interrupt request |
| irq_tx | output | 1 | Transmit interrupt request |
| irq_idle | output | 1 | Bus idle interrupt request |

## Verification
The bench builds the block with its default 8-bit divider and a two-stage clock synchronizer. It programs divider values 0, 1 and 2 at run time, so every half-period stays a few cycles long. It sweeps all 24 combinations of divider, edge scheme, polarity and bit order. For each one it acts as the far end: it samples the data output and drives the data input on the edges the requirements name, and it measures every half-period. This small configuration puts every edge pairing and both bit orders within reach of an exhaustive sweep. Overrun, the enable gates and slave mode under both edge schemes get directed runs.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int SIO_W = 8;

  localparam logic [1:0] A_CFG  = 2'd0;
  localparam logic [1:0] A_IEN  = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;

  localparam int IE_RX   = 0;
  localparam int IE_TX   = 1;
  localparam int IE_IDLE = 2;
  localparam int IE_CLR  = 7;

  typedef struct packed {
    logic sdo_oe;
    logic sck_oe;
    logic lsb_first;
    logic clk_inv;
    logic spi_mode;
    logic slave;
    logic rx_en;
    logic tx_en;
  } sio_cfg_t;
endpackage

// File: rtl/sio_baud.sv
module sio_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q == div);
    cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sio_engine.sv
module sio_engine #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] tx_byte,
  input  logic         slave,
  input  logic         spi,
  input  logic         lsb,
  input  logic         m_tick,
  input  logic         s_edge,
  input  logic         s_level,
  input  logic         sdi,
  output logic         busy,
  output logic         phase,
  output logic         sdo_bit,
  output logic         done,
  output logic [W-1:0] rx_byte
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic          busy_q, busy_d;
  logic          ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  tsh_q, tsh_d;
  logic [W-1:0]  rsh_q, rsh_d, rsh_new;
  logic          edge_ev, ph_new, lead, trail, smp, shf;

  always_comb begin
    edge_ev = busy_q && (slave ? s_edge : m_tick);
    ph_new  = slave ? s_level : ~ph_q;
    lead    = edge_ev && ph_new;
    trail   = edge_ev && !ph_new;
    // normal scheme: sample on trailing, drive on leading (not the first)
    // SPI scheme: sample on leading, drive on trailing
    smp     = spi ? lead : trail;
    shf     = spi ? trail : (lead && (cnt_q != '0));
    rsh_new = lsb ? {sdi, rsh_q[W-1:1]} : {rsh_q[W-2:0], sdi};
    done    = trail && (cnt_q == CW'(W-1));
    rx_byte = smp ? rsh_new : rsh_q;

    busy_d = busy_q;
    if (start)     busy_d = 1'b1;
    else if (done) busy_d = 1'b0;

    ph_d = ph_q;
    if (start)        ph_d = 1'b0;
    else if (edge_ev) ph_d = ph_new;

    cnt_d = cnt_q;
    if (start || done) cnt_d = '0;
    else if (trail)    cnt_d = cnt_q + 1'b1;

    tsh_d = tsh_q;
    if (start)    tsh_d = tx_byte;
    else if (shf) tsh_d = lsb ? {1'b1, tsh_q[W-1:1]} : {tsh_q[W-2:0], 1'b1};

    rsh_d = smp ? rsh_new : rsh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ph_q   <= 1'b0;
      cnt_q  <= '0;
      tsh_q  <= '1;
      rsh_q  <= '0;
    end else begin
      busy_q <= busy_d;
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      tsh_q  <= tsh_d;
      rsh_q  <= rsh_d;
    end
  end

  assign busy    = busy_q;
  assign phase   = ph_q;
  assign sdo_bit = lsb ? tsh_q[0] : tsh_q[W-1];
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
  import sio_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int SYNC_N = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       sck_in,
  input  logic       sdi,
  output logic       sck_out,
  output logic       sdo_out,
  output logic       irq_rx,
  output logic       irq_tx,
  output logic       irq_idle
);
  localparam int W = SIO_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  // external clock synchronizer with one extra stage for edge detection
  logic [SYNC_N:0] ssync_q;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) ssync_q <= '0;
    else         ssync_q <= {ssync_q[SYNC_N-1:0], sck_in};
  end

  sio_cfg_t         cfg_q, cfg_d;
  logic [2:0]       ien_q, ien_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [W-1:0]     txh_q, txh_d, rxh_q, rxh_d;
  logic             tx_empty_q, tx_empty_d, rx_full_q, rx_full_d, ovr_q, ovr_d;

  logic wr_cfg, wr_ien, wr_data, wr_div, rd_data, err_clr;
  logic idle_lvl, s_edge, s_level, start, m_tick, busy, phase, sdo_bit, done, bus_idle;
  logic [W-1:0] rx_byte;

  always_comb begin
    wr_cfg   = reg_wr && (reg_addr == A_CFG);
    wr_ien   = reg_wr && (reg_addr == A_IEN);
    wr_data  = reg_wr && (reg_addr == A_DATA);
    wr_div   = reg_wr && (reg_addr == A_STAT);
    rd_data  = reg_rd && (reg_addr == A_DATA);
    err_clr  = wr_ien && reg_wdata[IE_CLR];
    idle_lvl = ~cfg_q.clk_inv;
    s_level  = ssync_q[SYNC_N-1] ^ idle_lvl;
    s_edge   = ssync_q[SYNC_N-1] ^ ssync_q[SYNC_N];
    start    = cfg_q.tx_en && !tx_empty_q && !busy;
    bus_idle = !busy && tx_empty_q;
  end

  sio_baud #(.DIV_W(DIV_W)) i_baud (
    .clk(clk), .rst_n(rst_ni), .run(busy && !cfg_q.slave), .div(div_q), .tick(m_tick)
  );

  sio_engine #(.W(W)) i_engine (
    .clk(clk), .rst_n(rst_ni), .start(start), .tx_byte(txh_q),
    .slave(cfg_q.slave), .spi(cfg_q.spi_mode), .lsb(cfg_q.lsb_first),
    .m_tick(m_tick), .s_edge(s_edge), .s_level(s_level), .sdi(sdi),
    .busy(busy), .phase(phase), .sdo_bit(sdo_bit), .done(done), .rx_byte(rx_byte)
  );

  always_comb begin
    cfg_d = wr_cfg ? sio_cfg_t'(reg_wdata) : cfg_q;
    ien_d = wr_ien ? reg_wdata[2:0] : ien_q;
    div_d = wr_div ? reg_wdata[DIV_W-1:0] : div_q;
    txh_d = wr_data ? reg_wdata : txh_q;

    tx_empty_d = tx_empty_q;
    if (wr_data)    tx_empty_d = 1'b0;
    else if (start) tx_empty_d = 1'b1;

    rxh_d     = rxh_q;
    rx_full_d = rx_full_q;
    if (done && cfg_q.rx_en && !rx_full_q) begin
      rxh_d     = rx_byte;
      rx_full_d = 1'b1;
    end else if (rd_data) begin
      rx_full_d = 1'b0;
    end

    ovr_d = ovr_q;
    if (err_clr)                               ovr_d = 1'b0;
    else if (done && cfg_q.rx_en && rx_full_q) ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q      <= '0;
      ien_q      <= '0;
      div_q      <= '0;
      txh_q      <= '0;
      rxh_q      <= '0;
      tx_empty_q <= 1'b1;
      rx_full_q  <= 1'b0;
      ovr_q      <= 1'b0;
    end else begin
      cfg_q      <= cfg_d;
      ien_q      <= ien_d;
      div_q      <= div_d;
      txh_q      <= txh_d;
      rxh_q      <= rxh_d;
      tx_empty_q <= tx_empty_d;
      rx_full_q  <= rx_full_d;
      ovr_q      <= ovr_d;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CFG:   reg_rdata = cfg_q;
      A_IEN:   reg_rdata = {5'b0, ien_q};
      A_DATA:  reg_rdata = rxh_q;
      default: reg_rdata = {4'b0, ovr_q, bus_idle, tx_empty_q, rx_full_q};
    endcase
  end

  assign sck_out  = (cfg_q.sck_oe && !cfg_q.slave) ? (idle_lvl ^ phase) : idle_lvl;
  assign sdo_out  = cfg_q.sdo_oe ? sdo_bit : 1'b1;
  assign irq_rx   = ien_q[IE_RX] && rx_full_q;
  assign irq_tx   = ien_q[IE_TX] && tx_empty_q;
  assign irq_idle = ien_q[IE_IDLE] && bus_idle;
endmodule

// File: rtl/sio_checker.sv
module sio_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       rx_full,
  input logic       ovr,
  input logic       rx_en,
  input logic       err_clr,
  input logic       sdo_oe,
  input logic       sdo_out,
  input logic       sck_out,
  input logic       clk_inv,
  input logic [7:0] rx_hold
);
  assert_idle_sck_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck_out == !clk_inv));

  assert_frame_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  assert_rx_from_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(done));

  assert_keep_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rx_en && rx_full) |=> $stable(rx_hold));

  assert_ovr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |=> !ovr);

  assert_sdo_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> sdo_out);
endmodule

bind sync_serial_xcvr sio_checker i_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .rx_full(rx_full_q),
  .ovr(ovr_q), .rx_en(cfg_q.rx_en), .err_clr(err_clr), .sdo_oe(cfg_q.sdo_oe),
  .sdo_out(sdo_out), .sck_out(sck_out), .clk_inv(cfg_q.clk_inv), .rx_hold(rxh_q)
);

// File: tb/test_sync_serial_xcvr.sv
`timescale 1ns/1ps
module test_sync_serial_xcvr;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr, reg_rd, sck_in, sdi;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       sck_out, sdo_out, irq_rx, irq_tx, irq_idle;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  sync_serial_xcvr i_sync_serial_xcvr (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck_in(sck_in), .sdi(sdi),
    .sck_out(sck_out), .sdo_out(sdo_out), .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_idle(irq_idle)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  function automatic logic bit_at(input logic [7:0] b, input bit lsb, input int i);
    return lsb ? b[i] : b[7-i];
  endfunction

  // waits for bus idle, reporting any movement of sck_out or a low sdo_out
  task automatic wait_idle(output bit sck_moved, output bit sdo_low);
    logic s0;
    sck_moved = 0; sdo_low = 0;
    reg_addr = 2'd3;
    @(negedge clk); s0 = sck_out;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (sck_out != s0) sck_moved = 1;
      if (!sdo_out) sdo_low = 1;
      if (reg_rdata[2]) break;
    end
  endtask

  // master transfer, bench acts as far end
  task automatic mxfer(input int dv, input bit spi, input bit inv, input bit lsb,
                       input logic [7:0] txb, input logic [7:0] sdib);
    logic [7:0] got, v;
    logic prev;
    int edges, cyc, n;
    bit per_ok, smp_rise;
    string tag;
    tag = spi ? "R4" : "R3";
    smp_rise = ((spi ^ inv) == 1'b0);
    wr(2'd3, 8'(dv));
    wr(2'd0, {1'b1, 1'b1, lsb, inv, spi, 1'b0, 1'b1, 1'b1});
    chk(sck_out == !inv, "R2 idle level", sck_out, !inv);
    sdi = bit_at(sdib, lsb, 0);
    got = '0; edges = 0; cyc = 0; n = 0; per_ok = 1;
    wr(2'd2, txb);
    prev = sck_out;
    for (int k = 0; k < 2000 && edges < 16; k++) begin
      @(negedge clk);
      cyc++;
      if (sck_out != prev) begin
        edges++;
        if (edges > 1 && cyc != dv + 1) per_ok = 0;
        cyc = 0;
        prev = sck_out;
        if (sck_out == smp_rise) begin
          if (n < 8) got[lsb ? n : 7-n] = sdo_out;
          n++;
        end else if (n < 8) sdi = bit_at(sdib, lsb, n);
      end
    end
    chk(edges == 16, "R2 edge count", edges, 16);
    chk(per_ok, "R2 half period", cyc, dv + 1);
    chk(got == txb, {tag, lsb ? " R5 lsb-first out" : " R5 msb-first out"}, got, txb);
    repeat (3) @(negedge clk);
    rd(2'd3, v);
    chk(v[2:0] == 3'b111, "R6 R7 status after frame", v, 8'h07);
    rd(2'd2, v);
    chk(v == sdib, {tag, " R5 received byte"}, v, sdib);
    rd(2'd3, v);
    chk(v[0] == 1'b0, "R7 read clears full", v[0], 0);
  endtask

  task automatic sxfer(input bit spi, input bit inv, input logic [7:0] txb, input logic [7:0] sdib);
    logic [7:0] got, v;
    int n;
    sck_in = !inv;
    wr(2'd0, {1'b1, 1'b0, 1'b0, inv, spi, 1'b1, 1'b1, 1'b1});
    sdi = bit_at(sdib, 1'b0, 0);
    wr(2'd2, txb);
    repeat (4) @(negedge clk);
    got = '0; n = 0;
    for (int e = 0; e < 16; e++) begin
      repeat (6) @(negedge clk);
      if (n < 8) sdi = bit_at(sdib, 1'b0, n);
      if (spi == (e % 2 == 0)) begin
        if (n < 8) got[7-n] = sdo_out;
        n++;
      end
      sck_in = ~sck_in;
    end
    repeat (8) @(negedge clk);
    chk(sck_out == !inv, "R12 master clock held idle", sck_out, !inv);
    chk(got == txb, "R12 slave data out", got, txb);
    rd(2'd2, v);
    chk(v == sdib, "R12 slave data in", v, sdib);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    bit moved, low;
    int idx;
    rst_n = 1'b0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0; sck_in = 1; sdi = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    rd(2'd3, v); chk(v == 8'h06, "R1 status after reset", v, 8'h06);
    rd(2'd0, v); chk(v == 8'h00, "R1 config after reset", v, 8'h00);
    chk(sck_out == 1'b1, "R2 R10 idle clock high", sck_out, 1);
    chk(sdo_out == 1'b1, "R10 data output disabled", sdo_out, 1);
    chk({irq_rx, irq_tx, irq_idle} == 3'b000, "R9 irqs off", {irq_rx, irq_tx, irq_idle}, 0);
    wr(2'd1, 8'h07);
    #1 chk({irq_rx, irq_tx, irq_idle} == 3'b011, "R9 irqs enabled", {irq_rx, irq_tx, irq_idle}, 3);

    // exhaustive sweep: divider x scheme x polarity x order
    idx = 0;
    for (int dv = 0; dv < 3; dv++)
      for (int m = 0; m < 8; m++) begin
        mxfer(dv, m[0], m[1], m[2], 8'(8'hA5 ^ (idx * 37)), 8'(8'h3C + idx * 29));
        idx++;
      end

    // R7 R9: receive flag drives irq; overrun keeps held byte (R8)
    wr(2'd0, 8'hC3);
    wr(2'd3, 8'd1);
    sdi = 1'b0;
    wr(2'd2, 8'h5A);
    wait_idle(moved, low);
    #1 chk(irq_rx && irq_idle, "R9 rx and idle irq", {irq_rx, irq_idle}, 3);
    sdi = 1'b1;
    wr(2'd2, 8'h11);
    wait_idle(moved, low);
    rd(2'd3, v); chk(v[3] == 1'b1, "R8 overrun set", v, 8'h0F);
    rd(2'd2, v); chk(v == 8'h00, "R8 held byte kept", v, 8'h00);
    wr(2'd1, 8'h87);
    rd(2'd3, v); chk(v[3] == 1'b0, "R8 overrun cleared", v[3], 0);

    // R11: tx disabled leaves byte pending
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h00);
    repeat (40) @(negedge clk);
    rd(2'd3, v);
    chk(v[2:1] == 2'b00, "R11 R6 byte pending with tx off", v, 8'h00);
    chk(irq_tx == 1'b0, "R9 tx irq follows empty", irq_tx, 0);
    // enable tx only: clock and data outputs disabled, receive off
    wr(2'd0, 8'h01);
    wait_idle(moved, low);
    chk(!moved, "R10 clock held with output off", moved, 0);
    chk(!low, "R10 data held with output off", low, 0);
    rd(2'd3, v);
    chk(v[0] == 1'b0, "R11 rx off leaves full clear", v[0], 0);
    chk(v[1] == 1'b1, "R6 empty after start", v[1], 1);

    // R12: slave mode, both schemes
    sxfer(1'b0, 1'b0, 8'hC6, 8'h2B);
    sxfer(1'b1, 1'b0, 8'h39, 8'hD4);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule